// File: doc/BRIEF.md
# Dual-Counter Loop Integrator

This block sits between a binary phase comparator and an increment/decrement oscillator in an all-digital phase-locked loop. It integrates the comparator's direction bit over time. It keeps two separate modulo-K accumulators. Both only ever count upward, and the direction bit chooses which one of them advances on each fast clock tick. The fast clock runs at M times the loop center frequency, with M typically 8, 16 or 32.

The most significant bit of the advance-side accumulator is the lead pulse (`lead_o`). The most significant bit of the retard-side accumulator is the lag pulse (`lag_o`). The downstream oscillator inserts or removes half an output cycle on each rising edge of these pulses. A sustained direction therefore gives one pulse edge every K ticks. A direction that toggles evenly makes both accumulators advance more slowly and cancel out.

The direction input and both pulse outputs are plain control pins. There is no data stream here, so there is no valid/ready handshake.

Top module: `kloop_integrator`

## Requirements
- R1: While synchronous reset `rst_i` is high on a clock edge, both accumulators clear to 0, and `lead_o` and `lag_o` are low in the following cycle.
- R2: When `dir_i` is 0 on an edge, the lead accumulator advances by one and the lag accumulator holds.
- R3: When `dir_i` is 1 on an edge, the lag accumulator advances by one and the lead accumulator holds.
- R4: Each accumulator counts 0..K-1 and wraps from K-1 to 0, so a constant direction produces exactly one rising edge on its output every K enabled ticks.
- R5: `lead_o` is high exactly when the lead accumulator holds K/2 or more. After reset with `dir_i`=0, it first rises after K/2 edges and falls after K edges.
- R6: `lag_o` is high exactly when the lag accumulator holds K/2 or more. It follows the same timing as R5 for `dir_i`=1.
- R7: The two accumulators are independent. Ticks spent on one side leave the other side's phase unchanged, so with alternating direction each output rises after K-1 or K edges counted from reset.
- R8: K must be a power of two and at least 2. The parameter is checked at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, M times the loop center frequency |
| rst_i | input | 1 | Synchronous active-high reset |
| dir_i | input | 1 | Direction from the phase comparator: 0 advances the lead side, 1 advances the lag side |
| lead_o | output | 1 | Lead-side accumulator MSB (carry) |
| lag_o | output | 1 | Lag-side accumulator MSB (borrow) |

## Verification
The first two patterns hold the direction constant, low and then high. These check that only the selected output toggles, with a period of K, and that its first rise comes after K/2 ticks. The next pattern alternates the direction every tick. Here each side must reach its midpoint after about K ticks, which separates two independent counters from a shared up/down counter; a shared counter would never move. The last pattern runs uneven bursts that are resumed after the other side has advanced, which shows that each side keeps its phase while the other side counts. A reset applied mid-count shows that both sides return to zero together.

// File: rtl/kloop_pkg.sv
package kloop_pkg;
  typedef enum logic {
    DIR_LEAD = 1'b0,
    DIR_LAG  = 1'b1
  } dir_e;
endpackage

// File: rtl/kloop_side.sv
module kloop_side #(
  parameter int K = 16,
  localparam int W = $clog2(K)
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         msb_o
);
  logic [W-1:0] cnt_q;

  // modulus is a power of two, so natural overflow of W bits is the wrap
  always_ff @(posedge clk_i) begin
    if (rst_i)     cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign msb_o = cnt_q[W-1];

  a_r2_hold_when_idle: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> $stable(cnt_q));
  a_r4_wrap_to_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && cnt_q == W'(K-1)) |=> cnt_q == '0);
  a_r4_step_one: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && cnt_q != W'(K-1)) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/kloop_integrator.sv
module kloop_integrator #(
  parameter int K = 16
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic dir_i,
  output logic lead_o,
  output logic lag_o
);
  import kloop_pkg::*;
  localparam int W = (K < 2) ? 1 : $clog2(K);

  // R8: modulus must be a power of two, at least 2
  if (K < 2 || (K & (K - 1)) != 0) begin : g_bad_k
    $error("kloop_integrator: K must be a power of two >= 2");
  end

  dir_e         dir;
  logic [W-1:0] lead_cnt, lag_cnt;

  assign dir = dir_e'(dir_i);

  kloop_side #(.K(K)) u_lead (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(dir == DIR_LEAD),
    .cnt_o(lead_cnt), .msb_o(lead_o)
  );

  kloop_side #(.K(K)) u_lag (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(dir == DIR_LAG),
    .cnt_o(lag_cnt), .msb_o(lag_o)
  );

  a_r1_reset_clears: assert property (@(posedge clk_i)
    rst_i |=> (!lead_o && !lag_o && lead_cnt == '0 && lag_cnt == '0));
  a_r2_lag_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
    !dir_i |=> $stable(lag_cnt));
  a_r3_lead_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
    dir_i |=> $stable(lead_cnt));
  a_r5_lead_msb: assert property (@(posedge clk_i)
    lead_o == (lead_cnt >= W'(K/2)));
  a_r6_lag_msb: assert property (@(posedge clk_i)
    lag_o == (lag_cnt >= W'(K/2)));
  a_r7_one_side_moves: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> !($changed(lead_cnt) && $changed(lag_cnt)));
endmodule

// File: tb/kloop_integrator_tb_top.sv
`timescale 1ns/1ps
module kloop_integrator_tb_top;
  localparam int K = 16;
  logic clk = 0, rst = 1, dir = 0;
  logic lead, lag;
  int checks = 0, errors = 0;
  int mlead = 0, mlag = 0; // model counters

  always #2 clk = ~clk;

  kloop_integrator #(.K(K)) dut_i (
    .clk_i(clk), .rst_i(rst), .dir_i(dir), .lead_o(lead), .lag_o(lag));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // one edge with given dir; model updates; sample at negedge
  task automatic tick(input logic d);
    dir = d;
    @(posedge clk);
    if (rst) begin mlead = 0; mlag = 0; end
    else if (!d) mlead = (mlead + 1) % K;
    else mlag = (mlag + 1) % K;
    @(negedge clk);
  endtask

  task automatic cmp(input string req);
    chk({req, " lead"}, lead, mlead >= K/2);
    chk({req, " lag"},  lag,  mlag  >= K/2);
  endtask

  task automatic do_reset();
    rst = 1; tick(0); tick(1); rst = 0;
    cmp("R1");
  endtask

  task automatic t_const_lead();
    int rises = 0; logic prev;
    do_reset();
    for (int i = 1; i <= 2*K; i++) begin
      prev = lead; tick(0); cmp("R2");
      if (i == K/2)   chk("R5 first rise", lead, 1'b1);
      if (i == K/2-1) chk("R5 before rise", lead, 1'b0);
      if (i == K)     chk("R5 fall at wrap", lead, 1'b0);
      if (!prev && lead) rises++;
      chk("R2 lag idle", lag, 1'b0);
    end
    checks++; if (rises != 2) begin errors++;
      $display("FAIL R4 rises actual=%0d expected=2", rises); end
  endtask

  task automatic t_const_lag();
    do_reset();
    for (int i = 1; i <= 2*K; i++) begin
      tick(1); cmp("R3");
      if (i == K/2) chk("R6 first rise", lag, 1'b1);
      if (i == K)   chk("R6 fall", lag, 1'b0);
      chk("R3 lead idle", lead, 1'b0);
    end
  endtask

  task automatic t_alternate();
    do_reset();
    for (int i = 1; i <= 2*K; i++) begin
      tick(i[0] ? 1'b0 : 1'b1); cmp("R7");
      if (i == K-1) chk("R7 lead up", lead, 1'b1);
      if (i == K)   chk("R7 lag up", lag, 1'b1);
    end
  endtask

  task automatic t_bursts();
    do_reset();
    for (int i = 0; i < 5; i++) tick(0);
    for (int i = 0; i < 9; i++) tick(1);
    cmp("R7");
    for (int i = 0; i < 3; i++) tick(0);   // lead at 8
    chk("R7 lead resumes", lead, 1'b1);
    for (int i = 0; i < 7; i++) tick(1);   // lag 16 -> 0
    chk("R4 lag wrap", lag, 1'b0);
    cmp("R4");
    rst = 1; tick(0); rst = 0;
    cmp("R1 mid reset");
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_const_lead();
    t_const_lag();
    t_alternate();
    t_bursts();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule